// File: doc/BRIEF.md
# Link Frame Checker and Packet Depacketizer

This block sits behind the parallel receive side of a high-speed serial link between two chips. Each cycle it can take one 80-bit received frame. It checks the marker byte that opens every frame and keeps a lock status from the run of good and bad markers. It then takes apart the frames that hold data into 32-bit words, and passes header and payload words to a downstream demultiplexer over a valid/ready handshake.

Frame layout: bits [79:72] carry the marker, which must equal 0xBC. Bits [71:64] carry the frame type. Bits [63:32] carry the first word and bits [31:0] the second word. Within a word, bit 31 set marks a header. A header also holds a destination in [23:16], a source in [15:8], a payload length in [7:4] and a packet count in [3:0]. A word with bit 31 clear is payload. The block follows each packet and checks the word count against the header. It drops words that belong to no packet and raises a one-cycle format-error pulse where the structure breaks.

Top module: `link_frame_checker`

## Requirements
- R1: A frame accepted with a marker byte (bits [79:72]) other than 0xBC produces no output word and increments `errCount` by one.
- R2: `errCount` is 16 bits wide and saturates at 0xFFFF. It never wraps.
- R3: `inSync` sets after three consecutive accepted frames carry the correct marker. It clears after two consecutive frames carry a wrong marker. A single bad frame leaves it set. A frame is decoded only if `inSync` was already set when the frame was accepted.
- R4: Type byte (bits [71:64]) values: 0x00 is idle, 0x01 carries one word from bits [63:32], and 0x02 carries two words, [63:32] first and then [31:0]. An idle frame produces no output and no error. Any other type value produces no output and increments `errCount`.
- R5: After a header (bit 31 = 1, length in [7:4], non-zero count in [3:0]), the block forwards the header and then exactly the number of payload words (bit 31 = 0) that the length field gives, in arrival order.
- R6: If a header arrives while payload words are still owed, `fmtErr` pulses for one cycle, starting the cycle after the frame is accepted. That header is forwarded and opens a new packet.
- R7: A payload word that arrives with no packet open is dropped and pulses `fmtErr` once. Further stray payload words are dropped silently until the next valid header.
- R8: A header whose count field [3:0] is zero is dropped and pulses `fmtErr`. The payload words after it are dropped silently.
- R9: While `outReady` is low, `outValid` and `outData` hold steady. While the second word of a frame waits in the skid register, `rxReady` is low. No word is lost or reordered.
- R10: After reset, `outValid`, `inSync`, `fmtErr` and `errCount` are zero and `rxReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxValid | input | 1 | Received frame is present |
| rxFrame | input | 80 | Received frame: marker, type, two words |
| rxReady | output | 1 | Block accepts a frame this cycle |
| outValid | output | 1 | Output word is valid |
| outData | output | 32 | Header or payload word to the demultiplexer |
| outReady | input | 1 | Demultiplexer takes the word |
| inSync | output | 1 | Link marker lock status |
| fmtErr | output | 1 | One-cycle packet-structure error pulse |
| errCount | output | 16 | Saturating count of bad-marker and bad-type frames |

## Verification
The bench targets the packet-structure edge cases. These are a header that arrives one word early, a stray payload followed by a second stray, a zero-count header followed by a two-word payload frame, and two headers in one frame. A tracker that does not rearm its hunting state would pulse `fmtErr` on every stray word. A tracker that steps the second word from stale state would miss the early header inside a frame. For lock, the bench checks that the frame which completes the third good marker is still dropped. It also checks that one bad marker does not drop lock. Under backpressure, with a frame waiting at the input, a skid buffer that accepts while full would lose the second word. The counter is driven past 65535 to expose wrap-around.

// File: rtl/link_frame_checker_pkg.sv
package link_frame_checker_pkg;

  localparam logic [7:0] TYPE_IDLE = 8'h00;
  localparam logic [7:0] TYPE_ONE  = 8'h01;
  localparam logic [7:0] TYPE_TWO  = 8'h02;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic fire;   // a frame is taken this cycle
    logic keepA;  // first word goes downstream
    logic keepB;  // second word goes downstream
  } strobe_t;

endpackage

// File: rtl/link_frame_checker_ctrl.sv
module link_frame_checker_ctrl
  import link_frame_checker_pkg::*;
#(
  parameter logic [7:0] COMMA_BYTE = 8'hBC,
  parameter int WORD_W   = 32,
  parameter int SIZE_W   = 4,
  parameter int CNT_W    = 4,
  parameter int ERR_W    = 16,
  parameter int SYNC_SET = 3,
  parameter int SYNC_CLR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic              rxReady,
  input  logic [7:0]        commaByte,
  input  logic [7:0]        typeByte,
  input  logic [WORD_W-1:0] wordA,
  input  logic [WORD_W-1:0] wordB,
  output strobe_t           strobe,
  output logic              inSync,
  output logic              fmtErr,
  output logic [ERR_W-1:0]  errCount
);

  localparam int GOOD_W  = $clog2(SYNC_SET + 1);
  localparam int BAD_W   = $clog2(SYNC_CLR + 1);
  localparam int HDR_BIT = WORD_W - 1;
  localparam int SIZE_LO = CNT_W;
  localparam logic [GOOD_W-1:0] GOOD_MAX  = GOOD_W'(SYNC_SET);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(SYNC_SET - 1);
  localparam logic [BAD_W-1:0]  BAD_MAX   = BAD_W'(SYNC_CLR);
  localparam logic [BAD_W-1:0]  BAD_LAST  = BAD_W'(SYNC_CLR - 1);

  typedef struct packed {
    logic              keep;
    logic              err;
    logic [SIZE_W-1:0] remain;
    logic              hunting;
  } trk_t;

  // one word through the packet tracker
  function automatic trk_t stepWord(input logic [WORD_W-1:0] w,
                                    input logic [SIZE_W-1:0] rem,
                                    input logic hunt);
    trk_t r;
    r.keep    = 1'b0;
    r.err     = 1'b0;
    r.remain  = rem;
    r.hunting = hunt;
    if (w[HDR_BIT]) begin
      if (w[CNT_W-1:0] == '0) begin
        r.err     = 1'b1;
        r.remain  = '0;
        r.hunting = 1'b1;
      end else begin
        r.keep    = 1'b1;
        r.err     = (rem != '0);
        r.remain  = w[SIZE_LO +: SIZE_W];
        r.hunting = 1'b0;
      end
    end else if (rem != '0) begin
      r.keep   = 1'b1;
      r.remain = rem - SIZE_W'(1);
    end else begin
      r.err     = !hunt;
      r.hunting = 1'b1;
    end
    return r;
  endfunction

  logic [SIZE_W-1:0] remain;
  logic              hunting;
  logic [GOOD_W-1:0] goodRun;
  logic [BAD_W-1:0]  badRun;

  logic fire, commaOk, isIdle, hasA, hasB, typeKnown, process;
  logic wordErr;
  trk_t trkA, trkB;
  logic [SIZE_W-1:0] midRem, nextRem;
  logic midHunt, nextHunt;

  always_comb begin
    fire      = rxValid && rxReady;
    commaOk   = (commaByte == COMMA_BYTE);
    isIdle    = (typeByte == TYPE_IDLE);
    hasA      = (typeByte == TYPE_ONE) || (typeByte == TYPE_TWO);
    hasB      = (typeByte == TYPE_TWO);
    typeKnown = isIdle || hasA;
    process   = fire && commaOk && typeKnown && inSync;

    trkA     = stepWord(wordA, remain, hunting);
    midRem   = hasA ? trkA.remain  : remain;
    midHunt  = hasA ? trkA.hunting : hunting;
    trkB     = stepWord(wordB, midRem, midHunt);
    nextRem  = hasB ? trkB.remain  : midRem;
    nextHunt = hasB ? trkB.hunting : midHunt;

    wordErr  = process && ((hasA && trkA.err) || (hasB && trkB.err));

    strobe.fire  = fire;
    strobe.keepA = process && hasA && trkA.keep;
    strobe.keepB = process && hasB && trkB.keep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain   <= '0;
      hunting  <= 1'b1;
      inSync   <= 1'b0;
      goodRun  <= '0;
      badRun   <= '0;
      errCount <= '0;
      fmtErr   <= 1'b0;
    end else begin
      fmtErr <= wordErr;
      if (process) begin
        remain  <= nextRem;
        hunting <= nextHunt;
      end
      if (fire) begin
        if (commaOk) begin
          badRun <= '0;
          if (goodRun < GOOD_MAX) goodRun <= goodRun + GOOD_W'(1);
          if (goodRun >= GOOD_LAST) inSync <= 1'b1;
        end else begin
          goodRun <= '0;
          if (badRun < BAD_MAX) badRun <= badRun + BAD_W'(1);
          if (badRun >= BAD_LAST) begin
            inSync  <= 1'b0;
            remain  <= '0;
            hunting <= 1'b1;
          end
        end
        if ((!commaOk || !typeKnown) && (errCount != '1))
          errCount <= errCount + ERR_W'(1);
      end
    end
  end

  // R2: once full, the counter stays full
  assert_err_sat_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(errCount) == '1) |-> (errCount == '1));

  // R1: the counter moves only by one, and only after a taken frame
  assert_err_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (errCount != $past(errCount)) |-> ($past(fire) && (errCount == $past(errCount) + ERR_W'(1))));

  // R3: lock is gained only on a good marker and lost only on a bad one
  assert_sync_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inSync) |-> $past(fire && commaOk));
  assert_sync_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inSync) |-> $past(fire && !commaOk));

  // R6: an error pulse always follows a decoded frame
  assert_fmt_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    fmtErr |-> $past(process));

endmodule

// File: rtl/link_frame_checker_path.sv
module link_frame_checker_path
  import link_frame_checker_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] wordA,
  input  logic [WORD_W-1:0] wordB,
  input  logic              outReady,
  output logic              rxReady,
  output logic              outValid,
  output logic [WORD_W-1:0] outData
);

  logic              skidValid;
  logic [WORD_W-1:0] skidData;
  logic              pop;

  always_comb begin
    pop     = outValid && outReady;
    rxReady = !skidValid && (!outValid || outReady);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      skidValid <= 1'b0;
      skidData  <= '0;
    end else if (strobe.fire) begin
      // taking a frame implies the output register is free or draining
      outValid  <= strobe.keepA || strobe.keepB;
      if (strobe.keepA || strobe.keepB)
        outData <= strobe.keepA ? wordA : wordB;
      skidValid <= strobe.keepA && strobe.keepB;
      if (strobe.keepA && strobe.keepB)
        skidData <= wordB;
    end else if (pop) begin
      outValid  <= skidValid;
      if (skidValid) outData <= skidData;
      skidValid <= 1'b0;
    end
  end

  // R9: a stalled word stays put
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R9: the skid register is only ever behind a valid output word
  assert_skid_order_R9: assert property (@(posedge clk) disable iff (!rstN)
    skidValid |-> outValid);

  // R9: the skid fills only from a two-word frame
  assert_skid_fill_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(skidValid) |-> $past(strobe.fire && strobe.keepA && strobe.keepB));

endmodule

// File: rtl/link_frame_checker.sv
module link_frame_checker
  import link_frame_checker_pkg::*;
#(
  parameter logic [7:0] COMMA_BYTE = 8'hBC,
  parameter int WORD_W   = 32,
  parameter int SIZE_W   = 4,
  parameter int CNT_W    = 4,
  parameter int ERR_W    = 16,
  parameter int SYNC_SET = 3,
  parameter int SYNC_CLR = 2,
  localparam int FRAME_W = 2 * WORD_W + 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxValid,
  input  logic [FRAME_W-1:0] rxFrame,
  output logic               rxReady,
  output logic               outValid,
  output logic [WORD_W-1:0]  outData,
  input  logic               outReady,
  output logic               inSync,
  output logic               fmtErr,
  output logic [ERR_W-1:0]   errCount
);

  logic [7:0]        commaByte, typeByte;
  logic [WORD_W-1:0] wordA, wordB;
  strobe_t           strobe;

  always_comb begin
    commaByte = rxFrame[FRAME_W-1 -: 8];
    typeByte  = rxFrame[FRAME_W-9 -: 8];
    wordA     = rxFrame[2*WORD_W-1 -: WORD_W];
    wordB     = rxFrame[WORD_W-1:0];
  end

  link_frame_checker_ctrl #(
    .COMMA_BYTE(COMMA_BYTE), .WORD_W(WORD_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W),
    .ERR_W(ERR_W), .SYNC_SET(SYNC_SET), .SYNC_CLR(SYNC_CLR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxReady(rxReady),
    .commaByte(commaByte), .typeByte(typeByte), .wordA(wordA), .wordB(wordB),
    .strobe(strobe), .inSync(inSync), .fmtErr(fmtErr), .errCount(errCount)
  );

  link_frame_checker_path #(.WORD_W(WORD_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordA(wordA), .wordB(wordB),
    .outReady(outReady), .rxReady(rxReady), .outValid(outValid), .outData(outData)
  );

endmodule

// File: tb/tb_link_frame_checker.sv
module tb_link_frame_checker;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] GOOD = 8'hBC;
  localparam logic [7:0] BAD  = 8'h3C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [79:0] rxFrame = '0;
  logic        rxReady, outValid, outReady, inSync, fmtErr;
  logic [31:0] outData;
  logic [15:0] errCount;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_frame_checker dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxFrame(rxFrame), .rxReady(rxReady),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .inSync(inSync), .fmtErr(fmtErr), .errCount(errCount)
  );

  function automatic logic [79:0] fr(input logic [7:0] c, input logic [7:0] t,
                                     input logic [31:0] a, input logic [31:0] b);
    return {c, t, a, b};
  endfunction

  function automatic logic [31:0] hdr(input logic [7:0] d, input logic [7:0] s,
                                      input logic [3:0] len, input logic [3:0] cnt);
    return {1'b1, 7'd0, d, s, len, cnt};
  endfunction

  typedef struct packed {
    logic [79:0] frame;
    logic [1:0]  nWords;
    logic [31:0] w0;
    logic [31:0] w1;
    logic        err;
    logic [15:0] ecnt;
    logic        sync;
  } vec_t;

  function automatic vec_t mk(input logic [79:0] f, input logic [1:0] n,
                              input logic [31:0] a, input logic [31:0] b,
                              input logic e, input logic [15:0] ec);
    vec_t v;
    v.frame = f; v.nWords = n; v.w0 = a; v.w1 = b; v.err = e; v.ecnt = ec; v.sync = 1'b1;
    return v;
  endfunction

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    mk(fr(GOOD, 8'h00, 32'h0, 32'h0), 2'd0, 32'h0, 32'h0, 1'b0, 16'd0),                          // R4 idle
    mk(fr(GOOD, 8'h01, hdr(1,2,2,1), 32'h0), 2'd1, hdr(1,2,2,1), 32'h0, 1'b0, 16'd0),              // R5
    mk(fr(GOOD, 8'h02, 32'h0000_0A01, 32'h0000_0A02), 2'd2, 32'h0000_0A01, 32'h0000_0A02, 1'b0, 16'd0), // R5
    mk(fr(GOOD, 8'h02, hdr(3,4,1,2), 32'h0000_0B01), 2'd2, hdr(3,4,1,2), 32'h0000_0B01, 1'b0, 16'd0),   // R5
    mk(fr(GOOD, 8'h01, hdr(5,6,2,1), 32'h0), 2'd1, hdr(5,6,2,1), 32'h0, 1'b0, 16'd0),              // R5
    mk(fr(GOOD, 8'h01, 32'h0000_0C01, 32'h0), 2'd1, 32'h0000_0C01, 32'h0, 1'b0, 16'd0),            // R5
    mk(fr(GOOD, 8'h01, hdr(7,8,0,1), 32'h0), 2'd1, hdr(7,8,0,1), 32'h0, 1'b1, 16'd0),              // R6 early header
    mk(fr(GOOD, 8'h01, 32'h0000_0D01, 32'h0), 2'd0, 32'h0, 32'h0, 1'b1, 16'd0),                    // R7 stray
    mk(fr(GOOD, 8'h01, 32'h0000_0D02, 32'h0), 2'd0, 32'h0, 32'h0, 1'b0, 16'd0),                    // R7 silent
    mk(fr(GOOD, 8'h02, hdr(9,10,1,1), 32'h0000_0E01), 2'd2, hdr(9,10,1,1), 32'h0000_0E01, 1'b0, 16'd0), // R7 resync
    mk(fr(GOOD, 8'h01, hdr(1,1,1,0), 32'h0), 2'd0, 32'h0, 32'h0, 1'b1, 16'd0),                     // R8 zero count
    mk(fr(GOOD, 8'h02, 32'h0000_0F01, 32'h0000_0F02), 2'd0, 32'h0, 32'h0, 1'b0, 16'd0),            // R8 follow-on
    mk(fr(GOOD, 8'h05, hdr(2,2,0,1), 32'h0), 2'd0, 32'h0, 32'h0, 1'b0, 16'd1),                     // R4 bad type
    mk(fr(GOOD, 8'h02, hdr(2,2,1,1), hdr(3,3,0,1)), 2'd2, hdr(2,2,1,1), hdr(3,3,0,1), 1'b1, 16'd1),// R6 in-frame
    mk(fr(BAD,  8'h01, hdr(4,4,0,1), 32'h0), 2'd0, 32'h0, 32'h0, 1'b0, 16'd2),                     // R1 bad marker
    mk(fr(GOOD, 8'h01, hdr(4,4,0,1), 32'h0), 2'd1, hdr(4,4,0,1), 32'h0, 1'b0, 16'd2)               // R3 lock kept
  };

  function automatic string reqOf(input int i);
    case (i)
      0, 12:           return "R4";
      1, 2, 3, 4, 5:   return "R5";
      6, 13:           return "R6";
      7, 8, 9:         return "R7";
      10, 11:          return "R8";
      14:              return "R1";
      default:         return "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic err; logic v1; logic [31:0] d1; logic v2; logic [31:0] d2; logic v3;
    logic [15:0] ecnt; logic sync;
  } obs_t;

  // one frame, outReady high, everything drained before it
  task automatic sendFrame(input logic [79:0] f, output obs_t o);
    @(negedge clk); rxValid = 1'b1; rxFrame = f;
    @(negedge clk); rxValid = 1'b0;
    o.err = fmtErr; o.v1 = outValid; o.d1 = outData; o.ecnt = errCount; o.sync = inSync;
    @(negedge clk); o.v2 = outValid; o.d2 = outData;
    @(negedge clk); o.v3 = outValid;
  endtask

  task automatic expectFrame(input logic [79:0] f, input logic [1:0] n,
                             input logic [31:0] a, input logic [31:0] b,
                             input logic e, input logic [15:0] ec, input logic s,
                             input string req);
    obs_t o;
    logic [1:0] got;
    sendFrame(f, o);
    got = (o.v1 && !o.v3) ? (o.v2 ? 2'd2 : 2'd1) : ((!o.v2 && !o.v3) ? 2'd0 : 2'd3);
    check(got == n, req, "word count", 64'(got), 64'(n));
    if (n >= 2'd1) check(o.d1 == a, req, "first word", 64'(o.d1), 64'(a));
    if (n == 2'd2) check(o.d2 == b, req, "second word", 64'(o.d2), 64'(b));
    check(o.err == e, req, "fmtErr", 64'(o.err), 64'(e));
    check(o.ecnt == ec, req, "errCount", 64'(o.ecnt), 64'(ec));
    check(o.sync == s, req, "inSync", 64'(o.sync), 64'(s));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    outReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!outValid, "R10", "outValid", 64'(outValid), 0);
    check(!inSync, "R10", "inSync", 64'(inSync), 0);
    check(!fmtErr, "R10", "fmtErr", 64'(fmtErr), 0);
    check(errCount == 0, "R10", "errCount", 64'(errCount), 0);
    check(rxReady, "R10", "rxReady", 64'(rxReady), 1);

    // R3 lock: third good frame sets lock but is itself dropped
    expectFrame(fr(GOOD, 8'h00, 0, 0), 0, 0, 0, 0, 0, 0, "R3");
    expectFrame(fr(GOOD, 8'h00, 0, 0), 0, 0, 0, 0, 0, 0, "R3");
    expectFrame(fr(GOOD, 8'h01, hdr(1,1,0,1), 0), 0, 0, 0, 0, 0, 1, "R3");

    for (int i = 0; i < NV; i++)
      expectFrame(VECS[i].frame, VECS[i].nWords, VECS[i].w0, VECS[i].w1,
                  VECS[i].err, VECS[i].ecnt, VECS[i].sync, reqOf(i));

    // R3 lock loss after two bad markers, then decoding stops
    expectFrame(fr(BAD, 8'h00, 0, 0), 0, 0, 0, 0, 16'd3, 1, "R3");
    expectFrame(fr(BAD, 8'h00, 0, 0), 0, 0, 0, 0, 16'd4, 0, "R3");
    expectFrame(fr(GOOD, 8'h01, hdr(5,5,0,1), 0), 0, 0, 0, 0, 16'd4, 0, "R3");
    expectFrame(fr(GOOD, 8'h00, 0, 0), 0, 0, 0, 0, 16'd4, 0, "R3");
    expectFrame(fr(GOOD, 8'h00, 0, 0), 0, 0, 0, 0, 16'd4, 1, "R3");

    // R9 backpressure with a frame waiting at the input
    @(negedge clk);
    outReady = 1'b0; rxValid = 1'b1;
    rxFrame = fr(GOOD, 8'h02, hdr(6,6,1,1), 32'h0000_1234);
    @(negedge clk);
    rxFrame = fr(GOOD, 8'h01, hdr(7,7,0,1), 0);
    check(outValid && outData == hdr(6,6,1,1), "R9", "stalled head", 64'(outData), 64'(hdr(6,6,1,1)));
    check(!rxReady, "R9", "rxReady while skid full", 64'(rxReady), 0);
    repeat (3) @(negedge clk);
    check(outValid && outData == hdr(6,6,1,1), "R9", "held head", 64'(outData), 64'(hdr(6,6,1,1)));
    check(!rxReady, "R9", "rxReady still low", 64'(rxReady), 0);
    outReady = 1'b1;
    @(negedge clk);
    check(outValid && outData == 32'h0000_1234, "R9", "skid word", 64'(outData), 64'h1234);
    @(negedge clk);
    rxValid = 1'b0;
    check(outValid && outData == hdr(7,7,0,1), "R9", "waiting frame", 64'(outData), 64'(hdr(7,7,0,1)));
    @(negedge clk);
    check(!outValid, "R9", "drained", 64'(outValid), 0);

    // R2 saturation
    @(negedge clk);
    rxValid = 1'b1; rxFrame = fr(BAD, 8'h00, 0, 0);
    repeat (65540) @(negedge clk);
    rxValid = 1'b0;
    check(errCount == 16'hFFFF, "R2", "saturated count", 64'(errCount), 64'hFFFF);
    @(negedge clk); rxValid = 1'b1;
    @(negedge clk); rxValid = 1'b0;
    check(errCount == 16'hFFFF, "R2", "no wrap", 64'(errCount), 64'hFFFF);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule